// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a page directory entry and, for ordinary 4 KB pages, a page table entry through a single word-wide memory port that uses a request/ready handshake. A directory entry can also map a 4 MB large page directly when the large-page enable is set. The walker combines the permission bits of both levels and checks them against the access type, the privilege of the requester and the write-protect enable. On success it sets the accessed bit in the entries, and it also sets the dirty bit when the access is a write.

The result is either a physical address with a user-permission flag, or a fault with a three-bit error code. A real fault also stores the linear address in a fault-address register. A probe request walks the same tables but never writes memory and never changes the fault state; a failed probe only reports that no translation exists. A request that arrives while the core already has an abort pending fails at once, with no memory traffic.

Top module: `pgwalk_top`

## Requirements
- R1: The first memory access of a walk is a read at address {cfg_dir_page, 12'b0} + linear[31:22]*4.
- R2: For a 4 KB page the second read is at address {entry[31:12], 12'b0} + linear[21:12]*4, where entry is the directory entry just read.
- R3: fault_err encodes bit 0 = the faulting entry was present, bit 1 = write access, bit 2 = user access. A directory entry with bit 0 clear faults after a single read.
- R4: When directory entry bit 7 is set and cfg_large_en is 1, rsp_paddr = {entry[31:22], linear[21:0]}, the permissions come from that entry alone, and no table read occurs. When cfg_large_en is 0, bit 7 is ignored.
- R5: For a 4 KB page the table entry must have bit 0 set. The effective user bit (bit 2) and writable bit (bit 1) are the AND of both entries, and rsp_paddr = {table[31:12], linear[11:0]}.
- R6: A user access faults when the effective user bit is clear, unless req_override is 1.
- R7: A write faults when the effective writable bit is clear and either the access is a user access without override or cfg_wp_en is 1.
- R8: A successful non-probe walk writes the directory entry with bit 5 set, and then, for 4 KB pages only, writes the table entry with bit 5 set (bits 5 and 6 on a write). A large page gets only bit 5, even on a write. A fault writes nothing.
- R9: A probe request never writes memory. When it fails it gives rsp_ok=0 and rsp_fault=0 and leaves fault_err and fault_addr unchanged.
- R10: A request accepted while abort_pend is 1 completes one cycle later with rsp_ok=0, rsp_fault=0 and no memory access.
- R11: On success rsp_user is bit 2 of the last entry read. On a real fault fault_addr takes the linear address.
- R12: mem_req stays high with a stable mem_addr until mem_ready. rsp_done is a one-cycle pulse. req_ready is high only while idle, and there is no memory request while idle.
- R13: After reset req_ready=1, mem_req=0, rsp_done=0, fault_err=0 and fault_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access from user privilege |
| req_override | input | 1 | Suppress the user-privilege checks |
| req_probe | input | 1 | Probe only: no fault, no writes |
| abort_pend | input | 1 | An abort is already pending |
| cfg_dir_page | input | 20 | Page frame of the directory |
| cfg_wp_en | input | 1 | Write protection applies to supervisor |
| cfg_large_en | input | 1 | Large pages enabled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| rsp_done | output | 1 | Result valid pulse |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Real fault raised |
| rsp_user | output | 1 | User permission of the final entry |
| rsp_paddr | output | 32 | Physical address |
| fault_err | output | 3 | Error code of the last real fault |
| fault_addr | output | 32 | Linear address of the last real fault |

## Verification
The hardest situation to reach is a failed probe that must leave the fault state alone. A failed probe looks the same as a real fault unless a real fault with a different error code and a different address came before it. The stimulus therefore raises real faults at one linear address, and then sends failing probes both at that address and at a second address at the top of the directory. It checks that fault_err and fault_addr still hold the old values and that no memory write took place. The same vector walk also varies memory latency so that the handshake hold is exercised at every step of the walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  // entry bit positions (the walker decodes these)
  localparam int E_PRES  = 0;
  localparam int E_WR    = 1;
  localparam int E_USR   = 2;
  localparam int E_ACC   = 5;
  localparam int E_DIRTY = 6;
  localparam int E_BIG   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_TBL,
    ST_WR_DIR,
    ST_WR_TBL,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0]       la,
  input  logic [ADDR_W-OFF_W-1:0] dir_pg,
  input  logic [ADDR_W-OFF_W-1:0] pde_pg,
  input  logic [ADDR_W-OFF_W-1:0] pte_pg,
  output logic [ADDR_W-1:0]       dir_ea,
  output logic [ADDR_W-1:0]       tbl_ea,
  output logic [ADDR_W-1:0]       pa_small,
  output logic [ADDR_W-1:0]       pa_large
);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int BSH    = OFF_W - IDX_W;
  localparam int LG_OFF = OFF_W + IDX_W;
  localparam int LG_W   = ADDR_W - LG_OFF;
  localparam int PAD_W  = ADDR_W - IDX_W - BSH;

  logic [IDX_W-1:0] dir_idx, tbl_idx;

  assign dir_idx = la[ADDR_W-1:LG_OFF];
  assign tbl_idx = la[LG_OFF-1:OFF_W];

  assign dir_ea   = {dir_pg, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, dir_idx, {BSH{1'b0}}};
  assign tbl_ea   = {pde_pg, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, tbl_idx, {BSH{1'b0}}};
  assign pa_small = {pte_pg, la[OFF_W-1:0]};
  assign pa_large = {pde_pg[PG_W-1 -: LG_W], la[LG_OFF-1:0]};
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm (
  input  logic       present,
  input  logic       u_ok,
  input  logic       w_ok,
  input  logic       is_wr,
  input  logic       is_usr,
  input  logic       ovr,
  input  logic       wp_en,
  output logic       fault,
  output logic [2:0] err
);
  logic usr_chk;

  assign usr_chk = is_usr && !ovr;
  assign fault   = !present
                || (usr_chk && !u_ok)
                || (is_wr && !w_ok && (usr_chk || wp_en));
  assign err     = {is_usr, is_wr, present};
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic                    req_user,
  input  logic                    req_override,
  input  logic                    req_probe,
  input  logic                    abort_pend,
  input  logic [ADDR_W-OFF_W-1:0] cfg_dir_page,
  input  logic                    cfg_wp_en,
  input  logic                    cfg_large_en,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_wdata,
  input  logic                    mem_ready,
  input  logic [ADDR_W-1:0]       mem_rdata,
  output logic                    rsp_done,
  output logic                    rsp_ok,
  output logic                    rsp_fault,
  output logic                    rsp_user,
  output logic [ADDR_W-1:0]       rsp_paddr,
  output logic [2:0]              fault_err,
  output logic [ADDR_W-1:0]       fault_addr
);
  localparam int PG_W = ADDR_W - OFF_W;

  walk_st_e st, st_n;

  logic [ADDR_W-1:0] la_q, pde_q, pte_q, pde_ea_q, pte_ea_q;
  logic              wr_q, usr_q, ovr_q, prb_q, wp_q, lg_q, big_hit_q;

  logic [ADDR_W-1:0] la_cur, dir_ent;
  logic [ADDR_W-1:0] dir_ea, tbl_ea, pa_small, pa_large;
  logic              is_big;
  logic              pm_u, pm_w, pm_fault;
  logic [2:0]        pm_err;

  assign la_cur  = (st == ST_IDLE)   ? req_addr  : la_q;
  assign dir_ent = (st == ST_RD_DIR) ? mem_rdata : pde_q;
  assign is_big  = mem_rdata[E_BIG] && lg_q;

  pgwalk_addr #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) u_addr (
    .la      (la_cur),
    .dir_pg  (cfg_dir_page),
    .pde_pg  (dir_ent[ADDR_W-1:OFF_W]),
    .pte_pg  (mem_rdata[ADDR_W-1:OFF_W]),
    .dir_ea  (dir_ea),
    .tbl_ea  (tbl_ea),
    .pa_small(pa_small),
    .pa_large(pa_large)
  );

  // directory stage of a 4 KB walk checks presence only; the table
  // stage sees the AND of both levels
  always_comb begin
    if (st == ST_RD_TBL) begin
      pm_u = pde_q[E_USR] & mem_rdata[E_USR];
      pm_w = pde_q[E_WR]  & mem_rdata[E_WR];
    end else if (is_big) begin
      pm_u = mem_rdata[E_USR];
      pm_w = mem_rdata[E_WR];
    end else begin
      pm_u = 1'b1;
      pm_w = 1'b1;
    end
  end

  pgwalk_perm u_perm (
    .present(mem_rdata[E_PRES]),
    .u_ok   (pm_u),
    .w_ok   (pm_w),
    .is_wr  (wr_q),
    .is_usr (usr_q),
    .ovr    (ovr_q),
    .wp_en  (wp_q),
    .fault  (pm_fault),
    .err    (pm_err)
  );

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:   if (req_valid) st_n = abort_pend ? ST_DONE : ST_RD_DIR;
      ST_RD_DIR: if (mem_ready) begin
                   if (pm_fault)    st_n = ST_DONE;
                   else if (is_big) st_n = prb_q ? ST_DONE : ST_WR_DIR;
                   else             st_n = ST_RD_TBL;
                 end
      ST_RD_TBL: if (mem_ready) st_n = (pm_fault || prb_q) ? ST_DONE : ST_WR_DIR;
      ST_WR_DIR: if (mem_ready) st_n = big_hit_q ? ST_DONE : ST_WR_TBL;
      ST_WR_TBL: if (mem_ready) st_n = ST_DONE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      la_q       <= '0;
      pde_q      <= '0;
      pte_q      <= '0;
      pde_ea_q   <= '0;
      pte_ea_q   <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      ovr_q      <= 1'b0;
      prb_q      <= 1'b0;
      wp_q       <= 1'b0;
      lg_q       <= 1'b0;
      big_hit_q  <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_user   <= 1'b0;
      rsp_paddr  <= '0;
      fault_err  <= '0;
      fault_addr <= '0;
    end else begin
      st       <= st_n;
      rsp_done <= (st_n == ST_DONE);
      case (st)
        ST_IDLE: if (req_valid) begin
          la_q      <= req_addr;
          wr_q      <= req_write;
          usr_q     <= req_user;
          ovr_q     <= req_override;
          prb_q     <= req_probe;
          wp_q      <= cfg_wp_en;
          lg_q      <= cfg_large_en;
          pde_ea_q  <= dir_ea;
          rsp_ok    <= 1'b0;
          rsp_fault <= 1'b0;
        end
        ST_RD_DIR: if (mem_ready) begin
          pde_q     <= mem_rdata;
          pte_ea_q  <= tbl_ea;
          big_hit_q <= is_big;
          if (pm_fault) begin
            if (!prb_q) begin
              rsp_fault  <= 1'b1;
              fault_err  <= pm_err;
              fault_addr <= la_q;
            end
          end else if (is_big) begin
            rsp_ok    <= 1'b1;
            rsp_paddr <= pa_large;
            rsp_user  <= mem_rdata[E_USR];
          end
        end
        ST_RD_TBL: if (mem_ready) begin
          pte_q <= mem_rdata;
          if (pm_fault) begin
            if (!prb_q) begin
              rsp_fault  <= 1'b1;
              fault_err  <= pm_err;
              fault_addr <= la_q;
            end
          end else begin
            rsp_ok    <= 1'b1;
            rsp_paddr <= pa_small;
            rsp_user  <= mem_rdata[E_USR];
          end
        end
        default: ;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_RD_DIR) || (st == ST_RD_TBL) ||
                     (st == ST_WR_DIR) || (st == ST_WR_TBL);
  assign mem_we    = (st == ST_WR_DIR) || (st == ST_WR_TBL);
  assign mem_addr  = ((st == ST_RD_DIR) || (st == ST_WR_DIR)) ? pde_ea_q : pte_ea_q;

  always_comb begin
    if (st == ST_WR_DIR) begin
      mem_wdata        = pde_q;
      mem_wdata[E_ACC] = 1'b1;
    end else begin
      mem_wdata          = pte_q;
      mem_wdata[E_ACC]   = 1'b1;
      mem_wdata[E_DIRTY] = pte_q[E_DIRTY] | wr_q;
    end
  end

  logic [PG_W-1:0] unused_pg;
  assign unused_pg = '0;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_probe,
  input logic              abort_pend,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              rsp_done,
  input logic              rsp_ok,
  input logic              rsp_fault,
  input logic [2:0]        fault_err,
  input logic [ADDR_W-1:0] fault_addr
);
  logic prb_seen;

  always_ff @(posedge clk) begin
    if (rst)                                  prb_seen <= 1'b0;
    else if (req_valid && req_ready)          prb_seen <= req_probe;
    else if (rsp_done)                        prb_seen <= 1'b0;
  end

  a_r12_hold_req: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  a_r10_abort_fast: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && abort_pend) |=> (rsp_done && !rsp_ok && !mem_req));

  a_r9_probe_nowrite: assert property (@(posedge clk) disable iff (rst)
    prb_seen |-> !(mem_req && mem_we));

  a_r11_fault_addr_upd: assert property (@(posedge clk) disable iff (rst)
    !$stable(fault_addr) |-> (rsp_done && rsp_fault));

  a_r3_err_upd: assert property (@(posedge clk) disable iff (rst)
    !$stable(fault_err) |-> (rsp_done && rsp_fault));

  a_r12_ok_xor_fault: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !(rsp_ok && rsp_fault));
endmodule

bind pgwalk_top pgwalk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_probe (req_probe),
  .abort_pend(abort_pend),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .rsp_done  (rsp_done),
  .rsp_ok    (rsp_ok),
  .rsp_fault (rsp_fault),
  .fault_err (fault_err),
  .fault_addr(fault_addr)
);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic        req_override = 1'b0, req_probe = 1'b0, abort_pend = 1'b0;
  logic [31:0] req_addr = '0;
  logic [19:0] cfg_dir_page = 20'h00001;
  logic        cfg_wp_en = 1'b0, cfg_large_en = 1'b0;
  logic        req_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_done, rsp_ok, rsp_fault, rsp_user;
  logic [31:0] rsp_paddr, fault_addr;
  logic [2:0]  fault_err;

  pgwalk_top uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_user(req_user), .req_override(req_override),
    .req_probe(req_probe), .abort_pend(abort_pend),
    .cfg_dir_page(cfg_dir_page), .cfg_wp_en(cfg_wp_en), .cfg_large_en(cfg_large_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rsp_done(rsp_done), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_user(rsp_user),
    .rsp_paddr(rsp_paddr), .fault_err(fault_err), .fault_addr(fault_addr)
  );

  // memory model: 16 KB of words, programmable latency
  logic [31:0] tmem [0:4095];
  int          lat = 0, wcnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd1 = '0, rd2 = '0;

  always @(posedge clk) begin
    if (mem_ready) mem_ready <= 1'b0;
    else if (mem_req) begin
      if (wcnt >= lat) begin
        wcnt      <= 0;
        mem_ready <= 1'b1;
        mem_rdata <= tmem[mem_addr[13:2]];
        if (mem_we) begin
          tmem[mem_addr[13:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          if (rd_cnt == 0) rd1 <= mem_addr;
          else if (rd_cnt == 1) rd2 <= mem_addr;
          rd_cnt <= rd_cnt + 1;
        end
      end else wcnt <= wcnt + 1;
    end
  end

  int nchk = 0, nerr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] la, input logic wr, input logic usr,
                         input logic ovr, input logic prb);
    int guard;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; rd1 = '0; rd2 = '0;
    req_addr = la; req_write = wr; req_user = usr; req_override = ovr; req_probe = prb;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    if (!rsp_done) chk("R12 walk completes", 32'd0, 32'd1);
  endtask

  typedef struct packed {
    logic        wr, usr, ovr, prb, wp, lg;
    logic [31:0] pde, pte;
    logic        ok, flt;
    logic [2:0]  err;
    logic [31:0] pa;
    logic        eu;
  } vec_t;

  localparam logic [31:0] LA = 32'h0040_3ABC;  // dir idx 1, tbl idx 3
  localparam vec_t VT [0:16] = '{
    // R5 supervisor read
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_2007, 32'h1234_5007, 1'b1,1'b0,3'd0, 32'h1234_5ABC, 1'b1},
    // R5 user write
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_2007, 32'h1234_5007, 1'b1,1'b0,3'd0, 32'h1234_5ABC, 1'b1},
    // R6 user read, dir user bit clear
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_2003, 32'h1234_5007, 1'b0,1'b1,3'd5, 32'h0, 1'b0},
    // R6 same with override
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 32'h0000_2003, 32'h1234_5007, 1'b1,1'b0,3'd0, 32'h1234_5ABC, 1'b1},
    // R7 supervisor write, not writable, no write protect
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_2005, 32'h1234_5007, 1'b1,1'b0,3'd0, 32'h1234_5ABC, 1'b1},
    // R7 same with write protect
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0000_2005, 32'h1234_5007, 1'b0,1'b1,3'd3, 32'h0, 1'b0},
    // R7 user write with override, table not writable
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 32'h0000_2007, 32'h1234_5005, 1'b1,1'b0,3'd0, 32'h1234_5ABC, 1'b1},
    // R7 user write without override
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_2007, 32'h1234_5005, 1'b0,1'b1,3'd7, 32'h0, 1'b0},
    // R5 table entry not present
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_2007, 32'h1234_5006, 1'b0,1'b1,3'd0, 32'h0, 1'b0},
    // R3 directory entry not present
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_2006, 32'h1234_5007, 1'b0,1'b1,3'd6, 32'h0, 1'b0},
    // R4 large page
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 32'h0800_0087, 32'h1234_5007, 1'b1,1'b0,3'd0, 32'h0800_3ABC, 1'b1},
    // R4 bit 7 ignored when large pages off
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_2087, 32'h1234_5007, 1'b1,1'b0,3'd0, 32'h1234_5ABC, 1'b1},
    // R4 large page user write, not writable
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 32'h0800_0085, 32'h1234_5007, 1'b0,1'b1,3'd7, 32'h0, 1'b0},
    // R11 large supervisor page: rsp_user 0
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0800_0083, 32'h1234_5007, 1'b1,1'b0,3'd0, 32'h0800_3ABC, 1'b0},
    // R11 table user bit clear: rsp_user 0
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_2007, 32'h1234_5003, 1'b1,1'b0,3'd0, 32'h1234_5ABC, 1'b0},
    // R9 failing probe
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h0000_2003, 32'h1234_5007, 1'b0,1'b0,3'd0, 32'h0, 1'b0},
    // R9 successful probe
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0000_2007, 32'h1234_5007, 1'b1,1'b0,3'd0, 32'h1234_5ABC, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4096; k++) tmem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R13 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R13 rsp_done", {31'd0, rsp_done}, 32'd0);
    chk("R13 fault_err", {29'd0, fault_err}, 32'd0);
    chk("R13 fault_addr", fault_addr, 32'd0);

    for (int i = 0; i < 17; i++) begin
      logic [31:0] fa0;
      logic [2:0]  fe0;
      logic        big, four_k;
      vec_t        v;
      v = VT[i];
      lat = i % 3;
      tmem[32'h1004 >> 2] = v.pde;
      tmem[32'h200C >> 2] = v.pte;
      cfg_wp_en = v.wp;
      cfg_large_en = v.lg;
      fa0 = fault_addr;
      fe0 = fault_err;
      big = v.lg && v.pde[7] && v.pde[0];
      four_k = v.pde[0] && !(v.lg && v.pde[7]);
      run_req(LA, v.wr, v.usr, v.ovr, v.prb);
      chk($sformatf("R5-R7 vec%0d ok", i), {31'd0, rsp_ok}, {31'd0, v.ok});
      chk($sformatf("R6/R7 vec%0d fault", i), {31'd0, rsp_fault}, {31'd0, v.flt});
      chk($sformatf("R1 vec%0d dir addr", i), rd1, 32'h0000_1004);
      if (four_k) begin
        chk($sformatf("R2 vec%0d tbl addr", i), rd2, 32'h0000_200C);
        chk($sformatf("R2 vec%0d reads", i), rd_cnt, 32'd2);
      end else
        chk($sformatf("R3/R4 vec%0d single read", i), rd_cnt, 32'd1);
      if (v.ok) begin
        chk($sformatf("R4/R5 vec%0d paddr", i), rsp_paddr, v.pa);
        chk($sformatf("R11 vec%0d user", i), {31'd0, rsp_user}, {31'd0, v.eu});
      end
      if (v.flt) begin
        chk($sformatf("R3 vec%0d err", i), {29'd0, fault_err}, {29'd0, v.err});
        chk($sformatf("R11 vec%0d fault_addr", i), fault_addr, LA);
      end
      if (v.prb) begin
        chk($sformatf("R9 vec%0d no writes", i), wr_cnt, 32'd0);
        chk($sformatf("R9 vec%0d fault_addr kept", i), fault_addr, fa0);
        chk($sformatf("R9 vec%0d err kept", i), {29'd0, fault_err}, {29'd0, fe0});
      end else if (v.ok) begin
        chk($sformatf("R8 vec%0d dir entry", i), tmem[32'h1004 >> 2], v.pde | 32'h20);
        if (big) begin
          chk($sformatf("R8 vec%0d large writes", i), wr_cnt, 32'd1);
          chk($sformatf("R8 vec%0d tbl untouched", i), tmem[32'h200C >> 2], v.pte);
        end else begin
          chk($sformatf("R8 vec%0d writes", i), wr_cnt, 32'd2);
          chk($sformatf("R8 vec%0d tbl entry", i), tmem[32'h200C >> 2],
              v.pte | (v.wr ? 32'h60 : 32'h20));
        end
      end else
        chk($sformatf("R8 vec%0d fault no writes", i), wr_cnt, 32'd0);
    end

    // R9: failing probe at another address leaves fault state alone
    lat = 1;
    tmem[32'h1FFC >> 2] = 32'h0000_3006;
    run_req(32'hFFC0_1234, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 far probe ok", {31'd0, rsp_ok}, 32'd0);
    chk("R9 far probe fault", {31'd0, rsp_fault}, 32'd0);
    chk("R9 far probe fault_addr", fault_addr, LA);
    chk("R9 far probe err", {29'd0, fault_err}, 32'd7);

    // R1/R2 top directory index, R8 dirty on write
    tmem[32'h1FFC >> 2] = 32'h0000_3007;
    tmem[32'h3004 >> 2] = 32'hABCD_E007;
    run_req(32'hFFC0_1234, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 top dir addr", rd1, 32'h0000_1FFC);
    chk("R2 top tbl addr", rd2, 32'h0000_3004);
    chk("R5 top paddr", rsp_paddr, 32'hABCD_E234);
    chk("R8 top tbl dirty", tmem[32'h3004 >> 2], 32'hABCD_E067);

    // R10 abort pending
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    abort_pend = 1'b1; req_probe = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; abort_pend = 1'b0;
    chk("R10 done next cycle", {31'd0, rsp_done}, 32'd1);
    chk("R10 not ok", {31'd0, rsp_ok}, 32'd0);
    chk("R10 no fault", {31'd0, rsp_fault}, 32'd0);
    @(negedge clk);
    chk("R10 no memory access", rd_cnt + wr_cnt, 32'd0);
    chk("R12 done one cycle", {31'd0, rsp_done}, 32'd0);

    // R12 handshake hold with slow memory
    lat = 5;
    cfg_large_en = 1'b0;
    tmem[32'h1004 >> 2] = 32'h0000_2007;
    tmem[32'h200C >> 2] = 32'h1234_5007;
    @(negedge clk);
    req_addr = LA; req_write = 1'b0; req_user = 1'b0; req_override = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy not ready", {31'd0, req_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R12 request held", {31'd0, mem_req}, 32'd1);
    chk("R12 address held", mem_addr, 32'h0000_1004);
    for (int g = 0; g < 200 && !rsp_done; g++) @(negedge clk);
    chk("R12 slow walk ok", {31'd0, rsp_ok}, 32'd1);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule